// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART's line receiver and line transmitter, its receive and transmit FIFOs, and the CPU-visible data register. A two-bit channel mode decides where each byte goes. Bytes from the line can go to the receive FIFO, the transmit FIFO, both, or nowhere. CPU data writes can go to the transmit FIFO, the receive FIFO, or nowhere. CPU data reads pop the receive FIFO.

The block holds the UART control register. That register carries the receiver and transmitter enable and disable bits, two self-clearing FIFO flush bits, and the break start and stop bits. The block also gives the line receiver a free-space count and a ready flag. These are derived from whichever FIFOs the current mode fills.

The FIFOs are external. Both are show-ahead: the head byte is on `*_rdata` whenever the count is non-zero. All FIFO handshakes are single-cycle strobes.

Top module: `uart_mode_router`

## Requirements
- R1: Mode `mode_chan` encodes 0 normal, 1 automatic echo, 2 local loopback and 3 remote loopback. A line byte (`lrx_valid`) is pushed into the receive FIFO in modes 0 and 1, into the transmit FIFO in modes 3 and 1, and into neither in mode 2.
- R2: A CPU data write (`cpu_wr`) pushes `cpu_wdata` into the transmit FIFO in mode 0 and into the receive FIFO in mode 2. It is discarded in modes 1 and 3.
- R3: Receive FIFO pushes and CPU pops happen only while control bit 2 (receiver on) is 1 and control bit 3 (receiver off) is 0.
- R4: Transmit FIFO pushes happen only while control bit 4 (transmitter on) is 1 and control bit 5 (transmitter off) is 0.
- R5: A control write holding bit 0 raises `rxf_flush`, and one holding bit 1 raises `txf_flush`. Each flush lasts exactly the one cycle after the write. Bits 0 and 1 always read back as 0 in `ctrl_q`; the other bits read back as written.
- R6: `brk_o` is 1 exactly while the control register holds bit 7 = 1 and bit 8 = 0.
- R7: `lrx_space` is the receive FIFO free space in mode 0, the transmit FIFO free space in mode 3, and the smaller of the two in mode 1. In mode 2 it is the larger FIFO depth. `lrx_ready` is 1 when `lrx_space` is non-zero.
- R8: A push aimed at a full FIFO is dropped. If the target is the receive FIFO and the receiver is on, `rx_ovr` pulses in that same cycle.
- R9: After reset, `ctrl_q` is 0x128 (receiver off, transmitter off, stop break set), `brk_o` is 0, both flushes are 0 and `cpu_rdata` is 0.
- R10: A CPU read (`cpu_rd`) with the receiver on and a non-empty receive FIFO pops it, and `cpu_rdata` shows the head byte from the next cycle. In any other case the read pops nothing and `cpu_rdata` becomes 0. Without a read, `cpu_rdata` holds its value.
- R11: During a flush cycle, the flushed FIFO sees no push and no pop, and no overrun is raised for it.
- R12: `ltx_valid` is 1 when the transmit FIFO is non-empty. `ltx_data` is its head byte. `txf_pop` is `ltx_valid` and `ltx_ready` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_chan | input | 2 | Channel mode |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write data |
| ctrl_q | output | 9 | Control register value |
| brk_o | output | 1 | Break request to line transmitter |
| lrx_valid | input | 1 | Byte strobe from line receiver |
| lrx_data | input | DW | Byte from line receiver |
| lrx_ready | output | 1 | Room for a line byte |
| lrx_space | output | SP_W | Free space seen by the line receiver |
| ltx_valid | output | 1 | Byte available to line transmitter |
| ltx_data | output | DW | Byte to line transmitter |
| ltx_ready | input | 1 | Line transmitter takes the byte |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_wdata | output | DW | Receive FIFO write data |
| rxf_flush | output | 1 | Receive FIFO flush |
| rxf_pop | output | 1 | Receive FIFO pop |
| rxf_rdata | input | DW | Receive FIFO head byte |
| rxf_count | input | RXC_W | Receive FIFO fill level |
| txf_push | output | 1 | Transmit FIFO push |
| txf_wdata | output | DW | Transmit FIFO write data |
| txf_flush | output | 1 | Transmit FIFO flush |
| txf_pop | output | 1 | Transmit FIFO pop |
| txf_rdata | input | DW | Transmit FIFO head byte |
| txf_count | input | TXC_W | Transmit FIFO fill level |
| rx_ovr | output | 1 | Receive overrun event |
| cpu_wr | input | 1 | CPU data register write |
| cpu_wdata | input | DW | CPU write data |
| cpu_rd | input | 1 | CPU data register read |
| cpu_rdata | output | DW | CPU read data |

## Verification
The checker tests on every cycle the invariants that do not depend on history:
- no pushes take a path the current mode forbids;
- nothing is pushed into a full FIFO or popped from an empty one;
- enable gating, flush quiet cycles and the empty-read zero result always hold;
- flush and break react to control writes in the following cycle.

Some behaviour can only be shown by the bench's sweep over every mode, enable combination, strobe pattern and fill level of a small configuration. This covers the exact destination data, the space arithmetic and its minimum in echo mode, the overrun pulse at exactly full, and the head byte returned by a read.

// File: rtl/umr_pkg.sv
package umr_pkg;

   typedef enum logic [1:0] {
      CH_NORMAL    = 2'd0,
      CH_ECHO      = 2'd1,
      CH_LOCAL_LB  = 2'd2,
      CH_REMOTE_LB = 2'd3
   } chan_mode_e;

   localparam int CTRL_W      = 9;
   localparam int CB_RX_FLUSH = 0;
   localparam int CB_TX_FLUSH = 1;
   localparam int CB_RX_ON    = 2;
   localparam int CB_RX_OFF   = 3;
   localparam int CB_TX_ON    = 4;
   localparam int CB_TX_OFF   = 5;
   localparam int CB_BRK_GO   = 7;
   localparam int CB_BRK_HALT = 8;

   localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
   localparam logic [CTRL_W-1:0] CTRL_SELF_CLR =
      (CTRL_W'(1) << CB_RX_FLUSH) | (CTRL_W'(1) << CB_TX_FLUSH);

   // Destinations enabled by a channel mode
   typedef struct packed {
      logic line_rx;
      logic line_tx;
      logic cpu_rx;
      logic cpu_tx;
   } route_t;

   function automatic route_t decode_route(input chan_mode_e m);
      route_t r;
      r.line_rx = (m == CH_NORMAL) || (m == CH_ECHO);
      r.line_tx = (m == CH_REMOTE_LB) || (m == CH_ECHO);
      r.cpu_rx  = (m == CH_LOCAL_LB);
      r.cpu_tx  = (m == CH_NORMAL);
      return r;
   endfunction

endpackage

// File: rtl/umr_ctrl_reg.sv
module umr_ctrl_reg
   import umr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              rx_flush,
   output logic              tx_flush,
   output logic              rx_on,
   output logic              tx_on,
   output logic              brk
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RESET;
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         // flush bits act once, then are never stored
         rx_flush <= wr & wdata[CB_RX_FLUSH];
         tx_flush <= wr & wdata[CB_TX_FLUSH];
         if (wr) begin
            ctrl_q <= wdata & ~CTRL_SELF_CLR;
         end
      end
   end

   assign rx_on = ctrl_q[CB_RX_ON] & ~ctrl_q[CB_RX_OFF];
   assign tx_on = ctrl_q[CB_TX_ON] & ~ctrl_q[CB_TX_OFF];
   assign brk   = ctrl_q[CB_BRK_GO] & ~ctrl_q[CB_BRK_HALT];

endmodule

// File: rtl/umr_steer.sv
module umr_steer
   import umr_pkg::*;
#(
   parameter  int DW       = 8,
   parameter  int RX_DEPTH = 64,
   parameter  int TX_DEPTH = 64,
   localparam int RXC_W    = $clog2(RX_DEPTH + 1),
   localparam int TXC_W    = $clog2(TX_DEPTH + 1),
   localparam int MAXD     = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
   localparam int SP_W     = $clog2(MAXD + 1)
) (
   input  logic [1:0]       mode_chan,
   input  logic             rx_ok,
   input  logic             tx_ok,
   input  logic             lrx_valid,
   input  logic [DW-1:0]    lrx_data,
   input  logic             cpu_wr,
   input  logic [DW-1:0]    cpu_wdata,
   input  logic [RXC_W-1:0] rxf_count,
   input  logic [TXC_W-1:0] txf_count,
   output logic             rxf_push,
   output logic [DW-1:0]    rxf_wdata,
   output logic             txf_push,
   output logic [DW-1:0]    txf_wdata,
   output logic             rx_ovr,
   output logic [SP_W-1:0]  lrx_space,
   output logic             lrx_ready
);

   localparam logic [RXC_W-1:0] RX_FULL    = RXC_W'(RX_DEPTH);
   localparam logic [TXC_W-1:0] TX_FULL    = TXC_W'(TX_DEPTH);
   localparam logic [SP_W-1:0]  IDLE_SPACE = SP_W'(MAXD);

   chan_mode_e mode;
   route_t     rt;
   logic       rx_src, tx_src, rx_full, tx_full;
   logic [SP_W-1:0] rx_free, tx_free;

   assign mode = chan_mode_e'(mode_chan);
   assign rt   = decode_route(mode);

   // byte sources per destination; the mode keeps them mutually exclusive
   assign rx_src = (lrx_valid & rt.line_rx) | (cpu_wr & rt.cpu_rx);
   assign tx_src = (lrx_valid & rt.line_tx) | (cpu_wr & rt.cpu_tx);

   assign rx_full = (rxf_count == RX_FULL);
   assign tx_full = (txf_count == TX_FULL);

   assign rxf_push  = rx_src & rx_ok & ~rx_full;
   assign rx_ovr    = rx_src & rx_ok &  rx_full;
   assign rxf_wdata = rt.cpu_rx ? cpu_wdata : lrx_data;

   assign txf_push  = tx_src & tx_ok & ~tx_full;
   assign txf_wdata = rt.cpu_tx ? cpu_wdata : lrx_data;

   assign rx_free = SP_W'(RX_DEPTH) - SP_W'(rxf_count);
   assign tx_free = SP_W'(TX_DEPTH) - SP_W'(txf_count);

   always_comb begin
      unique case (mode)
         CH_NORMAL:   lrx_space = rx_free;
         CH_ECHO:     lrx_space = (rx_free < tx_free) ? rx_free : tx_free;
         CH_LOCAL_LB: lrx_space = IDLE_SPACE;
         default:     lrx_space = tx_free;
      endcase
   end

   assign lrx_ready = (lrx_space != '0);

endmodule

// File: rtl/umr_cpu_port.sv
module umr_cpu_port #(
   parameter  int DW       = 8,
   parameter  int RX_DEPTH = 64,
   localparam int RXC_W    = $clog2(RX_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_rd,
   input  logic             rx_ok,
   input  logic [RXC_W-1:0] rxf_count,
   input  logic [DW-1:0]    rxf_rdata,
   output logic             rxf_pop,
   output logic [DW-1:0]    cpu_rdata
);

   assign rxf_pop = cpu_rd & rx_ok & (rxf_count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rdata <= '0;
      end else if (cpu_rd) begin
         cpu_rdata <= rxf_pop ? rxf_rdata : '0;
      end
   end

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
   import umr_pkg::*;
#(
   parameter  int DW       = 8,
   parameter  int RX_DEPTH = 64,
   parameter  int TX_DEPTH = 64,
   localparam int RXC_W    = $clog2(RX_DEPTH + 1),
   localparam int TXC_W    = $clog2(TX_DEPTH + 1),
   localparam int MAXD     = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
   localparam int SP_W     = $clog2(MAXD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_chan,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              brk_o,
   input  logic              lrx_valid,
   input  logic [DW-1:0]     lrx_data,
   output logic              lrx_ready,
   output logic [SP_W-1:0]   lrx_space,
   output logic              ltx_valid,
   output logic [DW-1:0]     ltx_data,
   input  logic              ltx_ready,
   output logic              rxf_push,
   output logic [DW-1:0]     rxf_wdata,
   output logic              rxf_flush,
   output logic              rxf_pop,
   input  logic [DW-1:0]     rxf_rdata,
   input  logic [RXC_W-1:0]  rxf_count,
   output logic              txf_push,
   output logic [DW-1:0]     txf_wdata,
   output logic              txf_flush,
   output logic              txf_pop,
   input  logic [DW-1:0]     txf_rdata,
   input  logic [TXC_W-1:0]  txf_count,
   output logic              rx_ovr,
   input  logic              cpu_wr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic              cpu_rd,
   output logic [DW-1:0]     cpu_rdata
);

   // elaboration-time parameter checks
   if (DW < 5 || DW > 16) begin : g_bad_dw
      $error("uart_mode_router: DW must lie in 5..16");
   end
   if (RX_DEPTH < 2) begin : g_bad_rxd
      $error("uart_mode_router: RX_DEPTH must be at least 2");
   end
   if (TX_DEPTH < 2) begin : g_bad_txd
      $error("uart_mode_router: TX_DEPTH must be at least 2");
   end

   logic rx_on, tx_on, rx_ok, tx_ok;

   umr_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wdata    (ctrl_wdata),
      .ctrl_q   (ctrl_q),
      .rx_flush (rxf_flush),
      .tx_flush (txf_flush),
      .rx_on    (rx_on),
      .tx_on    (tx_on),
      .brk      (brk_o)
   );

   // a flushing FIFO is left alone for that cycle
   assign rx_ok = rx_on & ~rxf_flush;
   assign tx_ok = tx_on & ~txf_flush;

   umr_steer #(
      .DW       (DW),
      .RX_DEPTH (RX_DEPTH),
      .TX_DEPTH (TX_DEPTH)
   ) u_steer (
      .mode_chan (mode_chan),
      .rx_ok     (rx_ok),
      .tx_ok     (tx_ok),
      .lrx_valid (lrx_valid),
      .lrx_data  (lrx_data),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .rxf_count (rxf_count),
      .txf_count (txf_count),
      .rxf_push  (rxf_push),
      .rxf_wdata (rxf_wdata),
      .txf_push  (txf_push),
      .txf_wdata (txf_wdata),
      .rx_ovr    (rx_ovr),
      .lrx_space (lrx_space),
      .lrx_ready (lrx_ready)
   );

   umr_cpu_port #(
      .DW       (DW),
      .RX_DEPTH (RX_DEPTH)
   ) u_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_rd    (cpu_rd),
      .rx_ok     (rx_ok),
      .rxf_count (rxf_count),
      .rxf_rdata (rxf_rdata),
      .rxf_pop   (rxf_pop),
      .cpu_rdata (cpu_rdata)
   );

   // transmit drain toward the line
   assign ltx_valid = (txf_count != '0) & ~txf_flush;
   assign ltx_data  = txf_rdata;
   assign txf_pop   = ltx_valid & ltx_ready;

endmodule

// File: rtl/umr_checker.sv
module umr_checker #(
   parameter  int DW       = 8,
   parameter  int RX_DEPTH = 64,
   parameter  int TX_DEPTH = 64,
   localparam int RXC_W    = $clog2(RX_DEPTH + 1),
   localparam int TXC_W    = $clog2(TX_DEPTH + 1),
   localparam int MAXD     = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
   localparam int SP_W     = $clog2(MAXD + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_chan,
   input logic             ctrl_wr,
   input logic             wd_rx_flush,
   input logic             wd_brk_go,
   input logic             wd_brk_halt,
   input logic             q_rx_flush,
   input logic             q_rx_on,
   input logic             q_rx_off,
   input logic             q_tx_on,
   input logic             q_tx_off,
   input logic             brk_o,
   input logic             lrx_valid,
   input logic [SP_W-1:0]  lrx_space,
   input logic             ltx_ready,
   input logic             rxf_push,
   input logic             rxf_pop,
   input logic             rxf_flush,
   input logic [RXC_W-1:0] rxf_count,
   input logic             txf_push,
   input logic             txf_pop,
   input logic             txf_flush,
   input logic [TXC_W-1:0] txf_count,
   input logic             rx_ovr,
   input logic             cpu_rd,
   input logic [DW-1:0]    cpu_rdata
);

   localparam logic [RXC_W-1:0] RX_FULL = RXC_W'(RX_DEPTH);
   localparam logic [TXC_W-1:0] TX_FULL = TXC_W'(TX_DEPTH);

   assert_remote_no_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chan == 2'd3) |-> !rxf_push) else $error("R1 rx push in remote loopback");

   assert_local_no_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chan == 2'd2) |-> !txf_push) else $error("R1 tx push in local loopback");

   assert_cpu_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_chan == 2'd1 || mode_chan == 2'd3) && !lrx_valid) |-> (!rxf_push && !txf_push))
      else $error("R2 cpu write not discarded");

   assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_push || rxf_pop) |-> (q_rx_on && !q_rx_off)) else $error("R3 rx access while off");

   assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      txf_push |-> (q_tx_on && !q_tx_off)) else $error("R4 tx push while off");

   assert_flush_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wd_rx_flush) |=> (rxf_flush && !q_rx_flush)) else $error("R5 flush pulse");

   assert_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wd_brk_go && !wd_brk_halt) |=> brk_o) else $error("R6 break not raised");

   assert_normal_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chan == 2'd0) |-> (lrx_space == SP_W'(RX_DEPTH) - SP_W'(rxf_count)))
      else $error("R7 space in normal mode");

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_push |-> rxf_count != RX_FULL) and (txf_push |-> txf_count != TX_FULL))
      else $error("R8 push into full FIFO");

   assert_ovr_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr |-> (!rxf_push && rxf_count == RX_FULL)) else $error("R8 overrun with push");

   assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> (cpu_rd && rxf_count != '0)) else $error("R10 bad pop");

   assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !rxf_pop) |=> (cpu_rdata == '0)) else $error("R10 empty read not zero");

   assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_flush |-> (!rxf_push && !rxf_pop && !rx_ovr)) and
      (txf_flush |-> (!txf_push && !txf_pop))) else $error("R11 activity during flush");

   assert_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
      txf_pop |-> (ltx_ready && txf_count != '0)) else $error("R12 bad drain");

endmodule

bind uart_mode_router umr_checker #(
   .DW       (DW),
   .RX_DEPTH (RX_DEPTH),
   .TX_DEPTH (TX_DEPTH)
) u_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_chan   (mode_chan),
   .ctrl_wr     (ctrl_wr),
   .wd_rx_flush (ctrl_wdata[0]),
   .wd_brk_go   (ctrl_wdata[7]),
   .wd_brk_halt (ctrl_wdata[8]),
   .q_rx_flush  (ctrl_q[0]),
   .q_rx_on     (ctrl_q[2]),
   .q_rx_off    (ctrl_q[3]),
   .q_tx_on     (ctrl_q[4]),
   .q_tx_off    (ctrl_q[5]),
   .brk_o       (brk_o),
   .lrx_valid   (lrx_valid),
   .lrx_space   (lrx_space),
   .ltx_ready   (ltx_ready),
   .rxf_push    (rxf_push),
   .rxf_pop     (rxf_pop),
   .rxf_flush   (rxf_flush),
   .rxf_count   (rxf_count),
   .txf_push    (txf_push),
   .txf_pop     (txf_pop),
   .txf_flush   (txf_flush),
   .txf_count   (txf_count),
   .rx_ovr      (rx_ovr),
   .cpu_rd      (cpu_rd),
   .cpu_rdata   (cpu_rdata)
);

// File: tb/tb_uart_mode_router.sv
module tb_uart_mode_router;

   localparam int DW    = 8;
   localparam int RXD   = 4;
   localparam int TXD   = 6;
   localparam int RXC_W = $clog2(RXD + 1);
   localparam int TXC_W = $clog2(TXD + 1);
   localparam int SP_W  = $clog2(TXD + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       mode_chan = '0;
   logic             ctrl_wr = 1'b0;
   logic [8:0]       ctrl_wdata = '0;
   logic [8:0]       ctrl_q;
   logic             brk_o;
   logic             lrx_valid = 1'b0;
   logic [DW-1:0]    lrx_data = '0;
   logic             lrx_ready;
   logic [SP_W-1:0]  lrx_space;
   logic             ltx_valid;
   logic [DW-1:0]    ltx_data;
   logic             ltx_ready = 1'b0;
   logic             rxf_push, rxf_flush, rxf_pop;
   logic [DW-1:0]    rxf_wdata;
   logic [DW-1:0]    rxf_rdata = '0;
   logic [RXC_W-1:0] rxf_count = '0;
   logic             txf_push, txf_flush, txf_pop;
   logic [DW-1:0]    txf_wdata;
   logic [DW-1:0]    txf_rdata = '0;
   logic [TXC_W-1:0] txf_count = '0;
   logic             rx_ovr;
   logic             cpu_wr = 1'b0;
   logic [DW-1:0]    cpu_wdata = '0;
   logic             cpu_rd = 1'b0;
   logic [DW-1:0]    cpu_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   uart_mode_router #(.DW(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) dut (
      .clk(clk), .rst_n(rst_n), .mode_chan(mode_chan),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .brk_o(brk_o),
      .lrx_valid(lrx_valid), .lrx_data(lrx_data), .lrx_ready(lrx_ready), .lrx_space(lrx_space),
      .ltx_valid(ltx_valid), .ltx_data(ltx_data), .ltx_ready(ltx_ready),
      .rxf_push(rxf_push), .rxf_wdata(rxf_wdata), .rxf_flush(rxf_flush), .rxf_pop(rxf_pop),
      .rxf_rdata(rxf_rdata), .rxf_count(rxf_count),
      .txf_push(txf_push), .txf_wdata(txf_wdata), .txf_flush(txf_flush), .txf_pop(txf_pop),
      .txf_rdata(txf_rdata), .txf_count(txf_count),
      .rx_ovr(rx_ovr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
      .cpu_rdata(cpu_rdata)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [8:0] v);
      @(negedge clk);
      lrx_valid  = 1'b0;
      cpu_wr     = 1'b0;
      cpu_rd     = 1'b0;
      ctrl_wr    = 1'b1;
      ctrl_wdata = v;
      @(posedge clk);
      #1;
      ctrl_wr    = 1'b0;
      ctrl_wdata = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completion)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] prev_rd;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R9: reset state
      chk("R9", "ctrl_q", ctrl_q, 'h128);
      chk("R9", "brk_o", brk_o, 0);
      chk("R9", "cpu_rdata", cpu_rdata, 0);
      chk("R9", "rxf_flush", rxf_flush, 0);
      chk("R9", "txf_flush", txf_flush, 0);
      prev_rd = '0;

      // Sweep: mode x enable bits x strobes x fill levels
      for (int m = 0; m < 4; m++) begin
         for (int e = 0; e < 16; e++) begin
            wr_ctrl(9'(e << 2));
            chk("R5", "ctrl_q readback", ctrl_q, e << 2);
            for (int lv = 0; lv < 2; lv++) begin
               for (int cw = 0; cw < 2; cw++) begin
                  for (int cr = 0; cr < 2; cr++) begin
                     for (int rc = 0; rc <= RXD; rc++) begin
                        for (int tc = 0; tc <= TXD; tc++) begin
                           bit rx_ok, tx_ok, rx_src, tx_src, e_rxp, e_txp, e_ovr, e_pop, e_ltv;
                           int rxfree, txfree, e_sp, e_rd;
                           @(negedge clk);
                           mode_chan = 2'(m);
                           lrx_valid = 1'(lv);
                           cpu_wr    = 1'(cw);
                           cpu_rd    = 1'(cr);
                           rxf_count = RXC_W'(rc);
                           txf_count = TXC_W'(tc);
                           lrx_data  = 8'h5A ^ 8'(rc * 16 + tc);
                           cpu_wdata = 8'hC3 ^ 8'(tc * 16 + rc);
                           rxf_rdata = 8'h80 | 8'(rc * 8 + tc);
                           txf_rdata = 8'h11 + 8'(tc);
                           ltx_ready = 1'(lv ^ cw);
                           #1;
                           rx_ok  = ((e & 1) != 0) && ((e & 2) == 0);
                           tx_ok  = ((e & 4) != 0) && ((e & 8) == 0);
                           rx_src = (lv == 1 && (m == 0 || m == 1)) || (cw == 1 && m == 2);
                           tx_src = (lv == 1 && (m == 3 || m == 1)) || (cw == 1 && m == 0);
                           e_rxp  = rx_src && rx_ok && rc < RXD;
                           e_ovr  = rx_src && rx_ok && rc == RXD;
                           e_txp  = tx_src && tx_ok && tc < TXD;
                           rxfree = RXD - rc;
                           txfree = TXD - tc;
                           case (m)
                              0: e_sp = rxfree;
                              1: e_sp = (rxfree < txfree) ? rxfree : txfree;
                              2: e_sp = (RXD > TXD) ? RXD : TXD;
                              default: e_sp = txfree;
                           endcase
                           e_pop = cr == 1 && rx_ok && rc != 0;
                           e_ltv = tc != 0;
                           chk("R1 R2 R3", "rxf_push", rxf_push, e_rxp);
                           if (e_rxp)
                              chk("R1 R2", "rxf_wdata", rxf_wdata, (m == 2) ? cpu_wdata : lrx_data);
                           chk("R1 R2 R4", "txf_push", txf_push, e_txp);
                           if (e_txp)
                              chk("R1 R2", "txf_wdata", txf_wdata, (m == 0) ? cpu_wdata : lrx_data);
                           chk("R8", "rx_ovr", rx_ovr, e_ovr);
                           chk("R7", "lrx_space", lrx_space, e_sp);
                           chk("R7", "lrx_ready", lrx_ready, e_sp != 0);
                           chk("R10 R3", "rxf_pop", rxf_pop, e_pop);
                           chk("R12", "ltx_valid", ltx_valid, e_ltv);
                           chk("R12", "txf_pop", txf_pop, e_ltv && (lv ^ cw) == 1);
                           chk("R12", "ltx_data", ltx_data, 8'h11 + 8'(tc));
                           chk("R6", "brk_o idle", brk_o, 0);
                           e_rd = (cr == 1) ? (e_pop ? int'(rxf_rdata) : 0) : int'(prev_rd);
                           @(posedge clk);
                           #1;
                           chk("R10", "cpu_rdata", cpu_rdata, e_rd);
                           prev_rd = DW'(e_rd);
                        end
                     end
                  end
               end
            end
         end
      end

      // R5 / R11: flush pulses and quiet cycle
      wr_ctrl(9'h017);
      mode_chan = 2'd1;
      lrx_valid = 1'b1;
      cpu_rd    = 1'b1;
      ltx_ready = 1'b1;
      rxf_count = RXC_W'(1);
      txf_count = TXC_W'(1);
      #1;
      chk("R5", "rxf_flush", rxf_flush, 1);
      chk("R5", "txf_flush", txf_flush, 1);
      chk("R5", "ctrl_q self-clear", ctrl_q, 'h014);
      chk("R11", "rxf_push in flush", rxf_push, 0);
      chk("R11", "txf_push in flush", txf_push, 0);
      chk("R11", "rxf_pop in flush", rxf_pop, 0);
      chk("R11", "ltx_valid in flush", ltx_valid, 0);
      @(posedge clk);
      #1;
      chk("R5", "rxf_flush gone", rxf_flush, 0);
      chk("R5", "txf_flush gone", txf_flush, 0);
      chk("R11", "rxf_push after flush", rxf_push, 1);
      chk("R11", "txf_push after flush", txf_push, 1);
      chk("R11", "ltx_valid after flush", ltx_valid, 1);

      // R6: break bits
      wr_ctrl(9'h094);
      #1 chk("R6", "brk start", brk_o, 1);
      wr_ctrl(9'h194);
      #1 chk("R6", "brk both set", brk_o, 0);
      wr_ctrl(9'h114);
      #1 chk("R6", "brk stop only", brk_o, 0);
      wr_ctrl(9'h080);
      #1 chk("R6", "brk start again", brk_o, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule